// File: doc/BRIEF.md
# Blocked Prefix Scan Engine

This block takes a vector of N words and returns, for every position, the inclusive prefix of all words up to that position under one associative operator. The operator is chosen at start time from add, unsigned max, unsigned min, AND, OR and XOR. It uses only M = N/K processing lanes, where K = lg N, rather than one lane per word, so the cost of the datapath grows as N/lg N instead of N.

The work runs in three phases. In the first phase each lane walks its own contiguous group of K words one word per cycle and forms a running result. In the second phase the lane totals go through a log-step scan: in step j, lane i takes the total from lane i−2^j and combines it with its own, using only the values from the step before. In the third phase each lane except the first combines the scanned total of the group before it into its first K−1 words, one word per cycle.

To use the block, present the full vector and the operator code together with a one-cycle start pulse. The result is read when done pulses, and it stays on the output until the next accepted start.

Top module: `pscan_top`

## Requirements
- R1: The operator code selects the combine function: 0 add modulo 2^W, 1 unsigned max, 2 unsigned min, 3 bitwise AND, 4 bitwise OR, 5 bitwise XOR. Codes 6 and 7 act as add.
- R2: Output word i equals x0 op x1 op ... op xi, always with the earlier operand on the left. Word 0 equals x0.
- R3: Word i of both vectors sits at bits [i*W +: W]. Group g holds words g*K to g*K+K−1, with K = lg N and M = N/K groups.
- R4: done rises exactly K + lg M + (K−1) clock edges after the edge that samples start. With the defaults this is 9 edges.
- R5: done is high for exactly one cycle per accepted start.
- R6: A start pulse that arrives while a scan is running is ignored. The running scan completes with its original data, and its done timing does not change.
- R7: After done, the output vector holds its value until the next accepted start.
- R8: After reset, done is low and every output word is zero.
- R9: The input vector and the operator code are captured on the start edge. Changes to them later in the scan have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a scan when the block is idle |
| op_sel | input | 3 | Operator code, sampled with start |
| data_in | input | N*W | Input words, word i at bits [i*W +: W] |
| done | output | 1 | One-cycle pulse when the result is valid |
| data_out | output | N*W | Inclusive prefix words, same layout as data_in |

## Verification
The bench first runs the counting sequence 0..15 under add, whose result must be the triangular numbers. A design that dropped the fix-up or used the wrong group carry would break the run of sums at group boundaries. Words near 0xFFFF test that add wraps, and a design that saturated or widened would fail there. Pseudo-random vectors under max, min, AND, OR and XOR would expose a swapped or stale operand in the totals scan, which shows up in words of lanes two and three. A start pulse injected mid-scan, including one on the final fix-up edge, together with changes to the input and operator after start, would reveal a design that restarts or recaptures: done would move, or the result would belong to the wrong vector.

// File: rtl/pscan_pkg.sv
// Shared definitions for the blocked prefix scan engine.
// Assumes: operator codes are 3 bits; phase encoding is internal only.
package pscan_pkg;
    localparam logic [2:0] OPC_ADD = 3'd0;
    localparam logic [2:0] OPC_MAX = 3'd1;
    localparam logic [2:0] OPC_MIN = 3'd2;
    localparam logic [2:0] OPC_AND = 3'd3;
    localparam logic [2:0] OPC_OR  = 3'd4;
    localparam logic [2:0] OPC_XOR = 3'd5;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LOCAL  = 2'd1,
        PH_TOTALS = 2'd2,
        PH_FIX    = 2'd3
    } phase_t;
endpackage

// File: rtl/pscan_alu.sv
// Combinational combine unit: res = lhs op rhs.
// Assumes: lhs is always the earlier operand; max/min are unsigned;
// unused codes fall back to add (wrapping modulo 2^W).
module pscan_alu #(
    parameter int W = 16
) (
    input  logic [2:0]   op,
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [W-1:0] res
);
    import pscan_pkg::*;

    // Select the combine function for the current operator.
    always_comb begin
        case (op)
            OPC_MAX: res = (lhs > rhs) ? lhs : rhs;
            OPC_MIN: res = (lhs < rhs) ? lhs : rhs;
            OPC_AND: res = lhs & rhs;
            OPC_OR:  res = lhs | rhs;
            OPC_XOR: res = lhs ^ rhs;
            default: res = lhs + rhs;
        endcase
    end
endmodule

// File: rtl/pscan_ctrl.sv
// Sequencer for the three scan phases and the done pulse.
// Assumes: K >= 2 and LM >= 1; start is ignored unless idle.
module pscan_ctrl #(
    parameter int K  = 4,
    parameter int LM = 2,
    parameter int SW = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    output pscan_pkg::phase_t   phase,
    output logic [SW-1:0]       step,
    output logic                load,
    output logic                done
);
    import pscan_pkg::*;

    localparam logic [SW-1:0] LOC_LAST = SW'(K - 1);
    localparam logic [SW-1:0] TOT_LAST = SW'(LM - 1);
    localparam logic [SW-1:0] FIX_LAST = SW'(K - 2);

    // A new scan is accepted only from idle.
    assign load = start && (phase == PH_IDLE);

    // Advance phase and step counter; raise done on the last fix-up edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            step  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_LOCAL;
                        step  <= '0;
                    end
                end
                PH_LOCAL: begin
                    if (step == LOC_LAST) begin
                        phase <= PH_TOTALS;
                        step  <= '0;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                PH_TOTALS: begin
                    if (step == TOT_LAST) begin
                        phase <= PH_FIX;
                        step  <= '0;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                default: begin
                    if (step == FIX_LAST) begin
                        phase <= PH_IDLE;
                        step  <= '0;
                        done  <= 1'b1;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
            endcase
        end
    end

    // R5: done never lasts longer than one cycle.
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: done only ever follows the fix-up phase.
    a_r4_done_after_fixup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(phase) == PH_FIX));
endmodule

// File: rtl/pscan_lane.sv
// One lane: owns a group of K words. Phase 1 forms the running result
// of the group; phase 3 folds the previous group's total into words
// 0..K-2. Assumes: lane 0 never folds a carry.
module pscan_lane #(
    parameter int W   = 16,
    parameter int K   = 4,
    parameter int SW  = 2,
    parameter int IDX = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     op,
    input  logic           load,
    input  logic [K*W-1:0] grp_in,
    input  logic           loc_en,
    input  logic           fix_en,
    input  logic [SW-1:0]  step,
    input  logic [W-1:0]   carry,
    output logic [W-1:0]   acc,
    output logic [K*W-1:0] grp_out
);
    logic [W-1:0] items_q [K];
    logic [W-1:0] lhs;
    logic [W-1:0] res;

    // Earlier operand: running result in phase 1, previous group's total in phase 3.
    assign lhs = loc_en ? acc : carry;

    pscan_alu #(.W(W)) u_alu (
        .op  (op),
        .lhs (lhs),
        .rhs (items_q[step]),
        .res (res)
    );

    // Load the group, run the local scan, then apply the carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            for (int j = 0; j < K; j++) items_q[j] <= '0;
        end else if (load) begin
            acc <= '0;
            for (int j = 0; j < K; j++) items_q[j] <= grp_in[j*W +: W];
        end else if (loc_en) begin
            if (step == '0) begin
                acc <= items_q[0];
            end else begin
                acc            <= res;
                items_q[step]  <= res;
            end
        end else if (fix_en && (IDX != 0)) begin
            items_q[step] <= res;
        end
    end

    // Flatten the word array onto the group bus.
    for (genvar j = 0; j < K; j++) begin : g_out
        assign grp_out[j*W +: W] = items_q[j];
    end

    // R2: the first group needs no carry, so it is left alone in phase 3.
    if (IDX == 0) begin : g_lane0_chk
        a_r2_lane0_untouched: assert property (@(posedge clk) disable iff (!rst_n)
            fix_en |=> $stable(grp_out));
    end
endmodule

// File: rtl/pscan_totals.sv
// Log-step inclusive scan over the M group totals. In step j,
// lane i >= 2^j takes src[i-2^j] op src[i]; src is the lane
// totals in step 0 and the previous step's register otherwise.
// Assumes: M is a power of two and lg M <= 2^SW.
module pscan_totals #(
    parameter int W  = 16,
    parameter int M  = 4,
    parameter int LM = 2,
    parameter int SW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     op,
    input  logic           en,
    input  logic [SW-1:0]  step,
    input  logic [M*W-1:0] lane_tot,
    output logic [M*W-1:0] tot
);
    logic [W-1:0] src   [M];
    logic [W-1:0] tot_q [M];

    // Double buffering: read lane totals in step 0, previous results after.
    always_comb begin
        for (int i = 0; i < M; i++)
            src[i] = (step == '0) ? lane_tot[i*W +: W] : tot_q[i];
    end

    for (genvar i = 0; i < M; i++) begin : g_lane
        logic [W-1:0] cand [LM];
        logic [W-1:0] prt;
        logic         has;
        logic [W-1:0] res;

        for (genvar j = 0; j < LM; j++) begin : g_dist
            if (i >= (1 << j)) begin : g_yes
                assign cand[j] = src[i - (1 << j)];
            end else begin : g_no
                assign cand[j] = src[i];
            end
        end

        // Pick the partner at distance 2^step, if one exists.
        always_comb begin
            prt = src[i];
            has = 1'b0;
            for (int j = 0; j < LM; j++) begin
                if (step == SW'(j)) begin
                    prt = cand[j];
                    has = (i >= (1 << j));
                end
            end
        end

        pscan_alu #(.W(W)) u_alu (
            .op  (op),
            .lhs (prt),
            .rhs (src[i]),
            .res (res)
        );

        // Commit this step's value for lane i.
        always_ff @(posedge clk) begin
            if (!rst_n)  tot_q[i] <= '0;
            else if (en) tot_q[i] <= has ? res : src[i];
        end

        assign tot[i*W +: W] = tot_q[i];
    end

    // R2: once loaded, the first total keeps its value for the rest of the scan.
    a_r2_first_total_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (en && step != '0) |=> $stable(tot_q[0]));
endmodule

// File: rtl/pscan_top.sv
// Blocked prefix scan engine: N words, M = N/lg N lanes, three phases
// (local scan, totals scan, fix-up). Assumes N is a power of two and
// N/lg N is a power of two. Output word K-1 of each group comes from
// the scanned totals; the other words come from the lane registers.
module pscan_top #(
    parameter int N = 16,
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2:0]     op_sel,
    input  logic [N*W-1:0] data_in,
    output logic           done,
    output logic [N*W-1:0] data_out
);
    import pscan_pkg::*;

    localparam int K  = $clog2(N);
    localparam int M  = N / K;
    localparam int LM = $clog2(M);
    localparam int SW = $clog2(K);

    phase_t        phase;
    logic [SW-1:0] step;
    logic          load;
    logic [2:0]    op_q;
    logic [M*W-1:0] lane_acc;
    logic [M*W-1:0] tot;

    pscan_ctrl #(.K(K), .LM(LM), .SW(SW)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .phase (phase),
        .step  (step),
        .load  (load),
        .done  (done)
    );

    // Capture the operator with the accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)    op_q <= OPC_ADD;
        else if (load) op_q <= op_sel;
    end

    for (genvar g = 0; g < M; g++) begin : g_lane
        logic [K*W-1:0] grp;
        logic [W-1:0]   carry;

        if (g == 0) begin : g_c0
            assign carry = '0;
        end else begin : g_cn
            assign carry = tot[(g-1)*W +: W];
        end

        pscan_lane #(.W(W), .K(K), .SW(SW), .IDX(g)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .op      (op_q),
            .load    (load),
            .grp_in  (data_in[g*K*W +: K*W]),
            .loc_en  (phase == PH_LOCAL),
            .fix_en  (phase == PH_FIX),
            .step    (step),
            .carry   (carry),
            .acc     (lane_acc[g*W +: W]),
            .grp_out (grp)
        );

        // Words 0..K-2 from the lane; word K-1 is the scanned total.
        assign data_out[g*K*W +: (K-1)*W] = grp[(K-1)*W-1:0];
        assign data_out[(g*K+K-1)*W +: W] = tot[g*W +: W];

        // Keep the lint happy about the unused top word of grp.
        logic unused_top;
        assign unused_top = ^grp[K*W-1 -: W];
    end

    pscan_totals #(.W(W), .M(M), .LM(LM), .SW(SW)) u_tot (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op_q),
        .en       (phase == PH_TOTALS),
        .step     (step),
        .lane_tot (lane_acc),
        .tot      (tot)
    );

    // R6/R9: the operator cannot change while a scan is running.
    a_r6_op_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> $stable(op_q));

    // R7: the result holds while idle and no start arrives.
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !start) |=> $stable(data_out));
endmodule

// File: tb/pscan_top_tb.sv
// Bench: behavioural reference (sequential prefix kept in a queue),
// done compared on every clock of each run, words compared at done
// and again while the result is held.
module pscan_top_tb;
    localparam int N = 16;
    localparam int W = 16;
    localparam int LAT = 9; // K + lg M + (K-1) for N=16

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [2:0]     op_sel = 3'd0;
    logic [N*W-1:0] data_in = '0;
    logic           done;
    logic [N*W-1:0] data_out;

    int n_cmp = 0;
    int n_bad = 0;
    int unsigned seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    pscan_top #(.N(N), .W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .data_in(data_in), .done(done), .data_out(data_out)
    );

    function automatic int unsigned rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic int unsigned combine(int op, int unsigned a, int unsigned b);
        case (op)
            1: return (a > b) ? a : b;
            2: return (a < b) ? a : b;
            3: return a & b;
            4: return a | b;
            5: return a ^ b;
            default: return (a + b) & 32'h0000_FFFF;
        endcase
    endfunction

    task automatic check(string req, int unsigned act, int unsigned exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One scan: poke = 1 injects start pulses with other data mid-run.
    task automatic run(int op, int unsigned vals[N], bit poke);
        int unsigned exp_q[$];
        int unsigned acc;
        for (int i = 0; i < N; i++) begin
            acc = (i == 0) ? vals[0] : combine(op, acc, vals[i]);
            exp_q.push_back(acc);
        end
        @(negedge clk);
        op_sel = 3'(op);
        for (int i = 0; i < N; i++) data_in[i*W +: W] = W'(vals[i]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R9: scramble inputs after capture.
        op_sel = 3'(op + 1);
        for (int i = 0; i < N; i++) data_in[i*W +: W] = W'(rnd());
        check("R4 done low at start", done, 0);
        for (int c = 1; c <= LAT + 3; c++) begin
            @(negedge clk);
            check("R4/R5 done timing", done, (c == LAT) ? 1 : 0);
            if (c == LAT) begin
                for (int i = 0; i < N; i++)
                    check("R1/R2/R3/R9 word", data_out[i*W +: W], exp_q[i]);
            end
            start = 1'b0;
            // R6: starts during the run, including the last fix-up edge.
            if (poke && (c == 3 || c == LAT - 1)) begin
                start = 1'b1;
                op_sel = 3'd5;
            end
        end
        for (int i = 0; i < N; i++)
            check("R7 held word", data_out[i*W +: W], exp_q[i]);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int unsigned v[N];
        repeat (3) @(negedge clk);
        check("R8 done after reset", done, 0);
        for (int i = 0; i < N; i++) check("R8 zero word", data_out[i*W +: W], 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 done idle", done, 0);

        // R2/R3: counting sequence under add gives triangular numbers.
        for (int i = 0; i < N; i++) v[i] = i;
        run(0, v, 1'b0);
        check("R2 last triangular", data_out[(N-1)*W +: W], 120);

        // R1: add wraps modulo 2^W.
        for (int i = 0; i < N; i++) v[i] = 16'hFFF0 + i;
        run(0, v, 1'b0);

        // R1: each operator on pseudo-random words.
        for (int op = 1; op <= 5; op++) begin
            for (int i = 0; i < N; i++) v[i] = rnd() & 32'hFFFF;
            run(op, v, 1'b0);
        end

        // R1: unused codes act as add.
        for (int i = 0; i < N; i++) v[i] = rnd() & 32'h0FFF;
        run(6, v, 1'b0);
        run(7, v, 1'b0);

        // R6: start pulses while busy are ignored.
        for (int i = 0; i < N; i++) v[i] = rnd() & 32'hFFFF;
        run(4, v, 1'b1);
        for (int i = 0; i < N; i++) v[i] = N - i;
        run(0, v, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule